// File: doc/BRIEF.md
# Memory Access Permission Fault Checker

This block decides, for one memory access per cycle, whether that access must be aborted. It examines the access against two kinds of rule. The first kind applies whether or not translation is on: word alignment, and the low-vector window used in the legacy 26-bit addressing mode. The second kind applies only while translation is enabled: walk status flags, the per-domain access setting, and the access-permission (AP) field of the translation entry. When several problems are present at once, it reports the single highest-priority fault as a 4-bit status code, together with the domain number that goes with it.

The checking path is purely combinational. The abort flag, the fault code and the fault domain are valid in the same cycle that the access is presented. The block also holds a fault status register (code plus domain) and a fault address register. These load on the clock edge that follows an aborted *data* access. An aborted instruction fetch only raises the abort flag and leaves both registers untouched. The table walk itself and all cache behaviour live elsewhere: walk results arrive here as flags.

Top module: `mmu_perm_guard`

## Requirements
- R1: The 2-bit domain field at bits {domainNum,0}+1:{domainNum,0} of `domainAccess` selects the domain mode. Field values 00 and 10 raise a domain fault: code 1001 for a section, code 1011 for a small or large page.
- R2: Domain field 11 (manager) never produces a permission fault (code 1101 or 1111). Domain field 01 (client) checks the selected AP pair, and a denied access produces code 1101 (section) or 1111 (page).
- R3: AP decode, where "user" means `userMode`=1. AP=11 allows all accesses. AP=10 allows everything except user writes. AP=01 allows supervisor accesses only. AP=00 depends on the S and R bits: with S=1, R=0 it allows supervisor reads only; with S=0, R=1 it allows reads in both modes; with S=R=0, and also with S=R=1, it denies every access.
- R4: `descKind` is encoded as 00 section, 01 small page, 10 large page. A section uses `apSection`. A page uses `apPage[2q+1:2q]`, where q is `vaddr[11:10]` for a small page and `vaddr[15:14]` for a large page.
- R5: A data access (load or store, word or byte) with `mode26`=1 and `vaddr` in 0x00..0x1F aborts with code 0000. This holds whatever the value of `ctlM`. An instruction fetch never takes this fault.
- R6: With `ctlA`=1, a data word access with `vaddr[1:0]`≠0 aborts with code 0001, whatever the value of `ctlM`. Byte accesses and instruction fetches never take this fault. With `ctlM`=0, no fault other than the R5 and R6 faults occurs.
- R7: With `ctlM`=1, faults are ranked in this order: vector, alignment, level-one external abort 1100, level-two external abort 1110 (pages only), section translation 0101, page translation 0111 (pages only), domain, permission, and finally data external abort 1000 (section) or 1010 (page). The level-two flags are ignored for sections.
- R8: `faultDomain` equals `domainNum` for codes 1110, 0111, domain, permission and external-abort-on-data faults. For codes 0000, 0001, 1100 and 0101, and whenever there is no abort, it is 0000.
- R9: On the clock edge after an aborted data access, `fsrCode`/`fsrDomain` take the fault code and domain, and `farAddr` takes `vaddr`.
- R10: An aborted instruction fetch leaves `fsrCode`, `fsrDomain` and `farAddr` unchanged. With `accValid`=0, `abortOut` is 0.
- R11: After reset, `fsrCode`, `fsrDomain` and `farAddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the fault registers |
| accValid | input | 1 | An access is presented this cycle |
| vaddr | input | ADDR_W | Virtual address of the access |
| isData | input | 1 | 1 data access, 0 instruction fetch |
| isWrite | input | 1 | 1 write, 0 read |
| isWord | input | 1 | 1 word access, 0 byte access |
| userMode | input | 1 | 1 user, 0 supervisor |
| mode26 | input | 1 | Legacy 26-bit addressing mode active |
| ctlM | input | 1 | Translation enabled |
| ctlA | input | 1 | Alignment checking enabled |
| ctlS | input | 1 | AP=00 modifier S |
| ctlR | input | 1 | AP=00 modifier R |
| domainAccess | input | 2*DOM_FIELDS | Packed 2-bit domain mode fields |
| descKind | input | 2 | Entry kind: 00 section, 01 small, 10 large |
| domainNum | input | DOM_W | Domain number of the entry |
| apSection | input | 2 | AP pair of a section |
| apPage | input | 8 | Four AP pairs of a page, quarter 0 in bits 1:0 |
| l1ExtAbort | input | 1 | Level-one fetch externally aborted |
| l2ExtAbort | input | 1 | Level-two fetch externally aborted |
| l1Invalid | input | 1 | Level-one descriptor invalid |
| l2Invalid | input | 1 | Level-two descriptor invalid |
| dataExtAbort | input | 1 | External abort on the non-linefetch access |
| abortOut | output | 1 | Abort this access |
| faultCode | output | 4 | Winning fault code |
| faultDomain | output | DOM_W | Domain reported with the fault |
| fsrCode | output | 4 | Recorded fault code |
| fsrDomain | output | DOM_W | Recorded fault domain |
| farAddr | output | ADDR_W | Recorded fault address |

## Verification
The assertions assume that the walk flags and the entry fields are stable for the whole cycle in which `accValid` is high. They also assume that `descKind` never carries the unused value 11. The stimulus changes inputs only at falling edges and uses only the three defined kind encodings. The permission sweep drives the quarters that are not selected with the inverted AP value, so that picking the wrong pair changes the outcome. It also fills every domain field except the selected one with the inverted mode, for the same reason.

// File: rtl/mmu_perm_pkg.sv
package mmu_perm_pkg;

  typedef enum logic [1:0] {
    KIND_SECTION = 2'b00,
    KIND_SMALL   = 2'b01,
    KIND_LARGE   = 2'b10
  } descKind_e;

  localparam logic [3:0] FC_VECTOR     = 4'b0000;
  localparam logic [3:0] FC_ALIGN      = 4'b0001;
  localparam logic [3:0] FC_L1_EXT     = 4'b1100;
  localparam logic [3:0] FC_L2_EXT     = 4'b1110;
  localparam logic [3:0] FC_SEC_XLATE  = 4'b0101;
  localparam logic [3:0] FC_PAGE_XLATE = 4'b0111;
  localparam logic [3:0] FC_SEC_DOM    = 4'b1001;
  localparam logic [3:0] FC_PAGE_DOM   = 4'b1011;
  localparam logic [3:0] FC_SEC_PERM   = 4'b1101;
  localparam logic [3:0] FC_PAGE_PERM  = 4'b1111;
  localparam logic [3:0] FC_SEC_EXT    = 4'b1000;
  localparam logic [3:0] FC_PAGE_EXT   = 4'b1010;

  // condition flags produced by the datapath
  typedef struct packed {
    logic vecZone;
    logic misaligned;
    logic domDeny;
    logic domManager;
    logic permDeny;
  } accessFlags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       abort;
    logic       capture;
    logic       domValid;
    logic [3:0] code;
  } faultStrobe_t;

  function automatic logic apAllows(input logic [1:0] ap, input logic sBit,
                                    input logic rBit, input logic user,
                                    input logic write);
    logic ok;
    unique case (ap)
      2'b11: ok = 1'b1;
      2'b10: ok = !(user && write);
      2'b01: ok = !user;
      default: begin
        if (sBit && !rBit)      ok = !user && !write;
        else if (rBit && !sBit) ok = !write;
        else                    ok = 1'b0;
      end
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/mmu_perm_dpath.sv
module mmu_perm_dpath
  import mmu_perm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DOM_FIELDS = 16,
  parameter int VEC_BYTES  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       vaddr,
  input  logic                    isWrite,
  input  logic                    userMode,
  input  logic                    ctlS,
  input  logic                    ctlR,
  input  logic [2*DOM_FIELDS-1:0] domainAccess,
  input  logic [1:0]              descKind,
  input  logic [$clog2(DOM_FIELDS)-1:0] domainNum,
  input  logic [1:0]              apSection,
  input  logic [7:0]              apPage,
  input  faultStrobe_t            strobe,
  output accessFlags_t            flags,
  output logic [$clog2(DOM_FIELDS)-1:0] faultDomain,
  output logic [3:0]              fsrCode,
  output logic [$clog2(DOM_FIELDS)-1:0] fsrDomain,
  output logic [ADDR_W-1:0]       farAddr
);
  localparam int DOM_W    = $clog2(DOM_FIELDS);
  localparam int VEC_BITS = $clog2(VEC_BYTES);
  localparam int QUARTERS = 4;

  logic [1:0]          domField;
  logic [QUARTERS-1:0] quarterOk;
  logic [1:0]          quarterSel;
  logic                sectionOk;
  logic                pageOk;
  logic                isPage;

  assign domField = domainAccess[{domainNum, 1'b0} +: 2];
  assign isPage   = (descKind != KIND_SECTION);

  generate
    for (genvar q = 0; q < QUARTERS; q++) begin : g_quarter
      assign quarterOk[q] = apAllows(apPage[2*q +: 2], ctlS, ctlR, userMode, isWrite);
    end
  endgenerate

  assign quarterSel = (descKind == KIND_LARGE) ? vaddr[15:14] : vaddr[11:10];
  assign sectionOk  = apAllows(apSection, ctlS, ctlR, userMode, isWrite);
  assign pageOk     = quarterOk[quarterSel];

  always_comb begin
    flags.vecZone    = (vaddr[ADDR_W-1:VEC_BITS] == '0);
    flags.misaligned = (vaddr[1:0] != 2'b00);
    flags.domDeny    = !domField[0];
    flags.domManager = (domField == 2'b11);
    flags.permDeny   = isPage ? !pageOk : !sectionOk;
  end

  assign faultDomain = strobe.domValid ? domainNum : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsrCode   <= '0;
      fsrDomain <= '0;
      farAddr   <= '0;
    end else if (strobe.capture) begin
      fsrCode   <= strobe.code;
      fsrDomain <= faultDomain;
      farAddr   <= vaddr;
    end
  end

  logic unusedDom;
  assign unusedDom = ^{DOM_W{1'b0}};

endmodule

// File: rtl/mmu_perm_ctrl.sv
module mmu_perm_ctrl
  import mmu_perm_pkg::*;
(
  input  logic         accValid,
  input  logic         isData,
  input  logic         isWord,
  input  logic         mode26,
  input  logic         ctlM,
  input  logic         ctlA,
  input  logic [1:0]   descKind,
  input  logic         l1ExtAbort,
  input  logic         l2ExtAbort,
  input  logic         l1Invalid,
  input  logic         l2Invalid,
  input  logic         dataExtAbort,
  input  accessFlags_t flags,
  output faultStrobe_t strobe
);
  logic       found;
  logic       domValid;
  logic [3:0] code;
  logic       isPage;

  assign isPage = (descKind != KIND_SECTION);

  always_comb begin
    found    = 1'b1;
    domValid = 1'b0;
    code     = FC_VECTOR;
    if (isData && mode26 && flags.vecZone) begin
      code = FC_VECTOR;
    end else if (ctlA && isData && isWord && flags.misaligned) begin
      code = FC_ALIGN;
    end else if (!ctlM) begin
      found = 1'b0;
    end else if (l1ExtAbort) begin
      code = FC_L1_EXT;
    end else if (isPage && l2ExtAbort) begin
      code = FC_L2_EXT;  domValid = 1'b1;
    end else if (l1Invalid) begin
      code = FC_SEC_XLATE;
    end else if (isPage && l2Invalid) begin
      code = FC_PAGE_XLATE;  domValid = 1'b1;
    end else if (flags.domDeny) begin
      code = isPage ? FC_PAGE_DOM : FC_SEC_DOM;  domValid = 1'b1;
    end else if (!flags.domManager && flags.permDeny) begin
      code = isPage ? FC_PAGE_PERM : FC_SEC_PERM;  domValid = 1'b1;
    end else if (dataExtAbort) begin
      code = isPage ? FC_PAGE_EXT : FC_SEC_EXT;  domValid = 1'b1;
    end else begin
      found = 1'b0;
    end
  end

  always_comb begin
    strobe.abort    = accValid && found;
    strobe.capture  = accValid && found && isData;
    strobe.domValid = accValid && found && domValid;
    strobe.code     = (accValid && found) ? code : 4'b0000;
  end

endmodule

// File: rtl/mmu_perm_guard.sv
module mmu_perm_guard
  import mmu_perm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DOM_FIELDS = 16,
  parameter int VEC_BYTES  = 32,
  localparam int DOM_W     = $clog2(DOM_FIELDS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    accValid,
  input  logic [ADDR_W-1:0]       vaddr,
  input  logic                    isData,
  input  logic                    isWrite,
  input  logic                    isWord,
  input  logic                    userMode,
  input  logic                    mode26,
  input  logic                    ctlM,
  input  logic                    ctlA,
  input  logic                    ctlS,
  input  logic                    ctlR,
  input  logic [2*DOM_FIELDS-1:0] domainAccess,
  input  logic [1:0]              descKind,
  input  logic [DOM_W-1:0]        domainNum,
  input  logic [1:0]              apSection,
  input  logic [7:0]              apPage,
  input  logic                    l1ExtAbort,
  input  logic                    l2ExtAbort,
  input  logic                    l1Invalid,
  input  logic                    l2Invalid,
  input  logic                    dataExtAbort,
  output logic                    abortOut,
  output logic [3:0]              faultCode,
  output logic [DOM_W-1:0]        faultDomain,
  output logic [3:0]              fsrCode,
  output logic [DOM_W-1:0]        fsrDomain,
  output logic [ADDR_W-1:0]       farAddr
);
  accessFlags_t flags;
  faultStrobe_t strobe;

  mmu_perm_ctrl i_ctrl (
    .accValid(accValid), .isData(isData), .isWord(isWord), .mode26(mode26),
    .ctlM(ctlM), .ctlA(ctlA), .descKind(descKind),
    .l1ExtAbort(l1ExtAbort), .l2ExtAbort(l2ExtAbort),
    .l1Invalid(l1Invalid), .l2Invalid(l2Invalid), .dataExtAbort(dataExtAbort),
    .flags(flags), .strobe(strobe)
  );

  mmu_perm_dpath #(.ADDR_W(ADDR_W), .DOM_FIELDS(DOM_FIELDS), .VEC_BYTES(VEC_BYTES)) i_dpath (
    .clk(clk), .rstN(rstN), .vaddr(vaddr), .isWrite(isWrite), .userMode(userMode),
    .ctlS(ctlS), .ctlR(ctlR), .domainAccess(domainAccess), .descKind(descKind),
    .domainNum(domainNum), .apSection(apSection), .apPage(apPage),
    .strobe(strobe), .flags(flags), .faultDomain(faultDomain),
    .fsrCode(fsrCode), .fsrDomain(fsrDomain), .farAddr(farAddr)
  );

  assign abortOut  = strobe.abort;
  assign faultCode = strobe.code;

endmodule

// File: rtl/mmu_perm_guard_sva.sv
module mmu_perm_guard_sva #(
  parameter int ADDR_W     = 32,
  parameter int DOM_FIELDS = 16,
  parameter int VEC_BYTES  = 32,
  localparam int DOM_W     = $clog2(DOM_FIELDS),
  localparam int VEC_BITS  = $clog2(VEC_BYTES)
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    accValid,
  input logic [ADDR_W-1:0]       vaddr,
  input logic                    isData,
  input logic                    isWord,
  input logic                    mode26,
  input logic                    ctlM,
  input logic                    ctlA,
  input logic [2*DOM_FIELDS-1:0] domainAccess,
  input logic [DOM_W-1:0]        domainNum,
  input logic                    abortOut,
  input logic [3:0]              faultCode,
  input logic [DOM_W-1:0]        faultDomain,
  input logic [3:0]              fsrCode,
  input logic [DOM_W-1:0]        fsrDomain,
  input logic [ADDR_W-1:0]       farAddr
);
  logic [1:0] selField;
  logic       inVec;
  assign selField = domainAccess[{domainNum, 1'b0} +: 2];
  assign inVec    = (vaddr[ADDR_W-1:VEC_BITS] == '0);

  AST_IDLE_NO_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> !abortOut) else $error("idle abort"); // R10

  AST_VECTOR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && isData && mode26 && inVec) |-> (abortOut && faultCode == 4'b0000)) else $error("vector"); // R5

  AST_ALIGN_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && ctlA && isData && isWord && vaddr[1:0] != 2'b00 && !(mode26 && inVec))
      |-> (abortOut && faultCode == 4'b0001)) else $error("align"); // R6

  AST_MMU_OFF_LIMITED: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlM && abortOut) |-> (faultCode == 4'b0000 || faultCode == 4'b0001)) else $error("mmu off"); // R6

  AST_MANAGER_NO_PERM: assert property (@(posedge clk) disable iff (!rstN)
    (abortOut && selField == 2'b11) |-> (faultCode != 4'b1101 && faultCode != 4'b1111)) else $error("manager"); // R2

  AST_DATA_RECORDED: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && isData && abortOut) |=> (farAddr == $past(vaddr) && fsrCode == $past(faultCode)
      && fsrDomain == $past(faultDomain))) else $error("record"); // R9

  AST_FETCH_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rstN)
    (!(accValid && isData && abortOut)) |=> ($stable(fsrCode) && $stable(fsrDomain) && $stable(farAddr)))
      else $error("keep"); // R10

  AST_NO_DOMAIN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !abortOut |-> faultDomain == '0) else $error("domain"); // R8

endmodule

bind mmu_perm_guard mmu_perm_guard_sva #(.ADDR_W(ADDR_W), .DOM_FIELDS(DOM_FIELDS), .VEC_BYTES(VEC_BYTES)) i_sva (
  .clk(clk), .rstN(rstN), .accValid(accValid), .vaddr(vaddr), .isData(isData),
  .isWord(isWord), .mode26(mode26), .ctlM(ctlM), .ctlA(ctlA),
  .domainAccess(domainAccess), .domainNum(domainNum), .abortOut(abortOut),
  .faultCode(faultCode), .faultDomain(faultDomain), .fsrCode(fsrCode),
  .fsrDomain(fsrDomain), .farAddr(farAddr)
);

// File: tb/test_mmu_perm_guard.sv
`timescale 1ns/1ps
module test_mmu_perm_guard;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid, isData, isWrite, isWord, userMode, mode26;
  logic ctlM, ctlA, ctlS, ctlR;
  logic [31:0] vaddr, domainAccess;
  logic [1:0] descKind, apSection;
  logic [3:0] domainNum;
  logic [7:0] apPage;
  logic l1ExtAbort, l2ExtAbort, l1Invalid, l2Invalid, dataExtAbort;
  logic abortOut;
  logic [3:0] faultCode, faultDomain, fsrCode, fsrDomain;
  logic [31:0] farAddr;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mmu_perm_guard i_mmu_perm_guard (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    accValid = 1; isData = 1; isWrite = 0; isWord = 0; userMode = 0; mode26 = 0;
    ctlM = 1; ctlA = 0; ctlS = 0; ctlR = 0; vaddr = 32'h4000_0000;
    domainAccess = '1; descKind = 2'b00; domainNum = 4'd9; apSection = 2'b11; apPage = 8'hFF;
    l1ExtAbort = 0; l2ExtAbort = 0; l1Invalid = 0; l2Invalid = 0; dataExtAbort = 0;
  endtask

  // permission rule per R3
  function automatic logic refAllow(input logic [1:0] ap, input logic s, input logic r,
                                    input logic u, input logic w);
    logic rd, wr;
    rd = 0; wr = 0;
    if (ap == 2'b11) begin rd = 1; wr = 1; end
    else if (ap == 2'b10) begin rd = 1; wr = !u; end
    else if (ap == 2'b01) begin rd = !u; wr = !u; end
    else if (s && !r) begin rd = !u; wr = 0; end
    else if (r && !s) begin rd = 1; wr = 0; end
    return w ? wr : rd;
  endfunction

  task automatic expectOut(input string tag, input logic ab, input logic [3:0] code,
                           input logic [3:0] dom);
    #1;
    check({tag, " abort"}, abortOut, ab);
    check({tag, " code"}, faultCode, code);
    check({tag, " domain"}, faultDomain, dom);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    defaults();
    accValid = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R11 fsrCode", fsrCode, 0);
    check("R11 fsrDomain", fsrDomain, 0);
    check("R11 farAddr", farAddr, 0);

    // permission and domain sweep: R1 R2 R3 R4
    for (int dv = 0; dv < 4; dv++)
      for (int ap = 0; ap < 4; ap++)
        for (int sr = 0; sr < 4; sr++)
          for (int u = 0; u < 2; u++)
            for (int w = 0; w < 2; w++)
              for (int k = 0; k < 3; k++)
                for (int q = 0; q < 4; q++) begin
                  logic [1:0] apv, inv, qb;
                  logic allow, pg, ab;
                  logic [3:0] code;
                  @(negedge clk);
                  defaults();
                  apv = ap[1:0]; inv = ~apv; qb = q[1:0];
                  ctlS = sr[1]; ctlR = sr[0]; userMode = u[0]; isWrite = w[0];
                  descKind = k[1:0];
                  for (int f = 0; f < 16; f++)
                    domainAccess[2*f +: 2] = (f == 9) ? dv[1:0] : ~dv[1:0];
                  apSection = (k == 0) ? apv : inv;
                  apPage = {inv, inv, inv, inv};
                  if (k != 0) apPage[2*q +: 2] = apv;
                  if (k == 2) vaddr = 32'h4000_0000 | ({30'd0, qb} << 14) | ({30'd0, ~qb} << 10);
                  else        vaddr = 32'h4000_0000 | ({30'd0, qb} << 10) | ({30'd0, ~qb} << 14);
                  pg = (k != 0);
                  allow = refAllow(apv, sr[1], sr[0], u[0], w[0]);
                  ab = 1; code = 0;
                  if (dv == 0 || dv == 2) code = pg ? 4'b1011 : 4'b1001;
                  else if (dv == 1 && !allow) code = pg ? 4'b1111 : 4'b1101;
                  else ab = 0;
                  expectOut("R1 R2 R3 R4 sweep", ab, code, ab ? 4'd9 : 4'd0);
                end

    // priority ladder on a small page: R7 R8
    @(negedge clk); defaults();
    descKind = 2'b01; domainAccess = '0;
    l1ExtAbort = 1; l2ExtAbort = 1; l1Invalid = 1; l2Invalid = 1; dataExtAbort = 1;
    expectOut("R7 l1 ext", 1, 4'b1100, 0);
    @(negedge clk); l1ExtAbort = 0;
    expectOut("R7 l2 ext", 1, 4'b1110, 9);
    @(negedge clk); l2ExtAbort = 0;
    expectOut("R7 section xlate", 1, 4'b0101, 0);
    @(negedge clk); l1Invalid = 0;
    expectOut("R7 page xlate", 1, 4'b0111, 9);
    @(negedge clk); l2Invalid = 0;
    expectOut("R7 page domain", 1, 4'b1011, 9);
    @(negedge clk); domainAccess = {16{2'b01}}; apPage = 8'h00;
    expectOut("R7 page perm", 1, 4'b1111, 9);
    @(negedge clk); apPage = 8'hFF;
    expectOut("R7 page ext", 1, 4'b1010, 9);
    @(negedge clk); dataExtAbort = 0;
    expectOut("R7 clean", 0, 4'b0000, 0);
    @(negedge clk); descKind = 2'b00; l2ExtAbort = 1; l2Invalid = 1; dataExtAbort = 1;
    expectOut("R7 section ignores l2", 1, 4'b1000, 9);

    // vector and alignment: R5 R6
    @(negedge clk); defaults(); ctlM = 0; mode26 = 1; ctlA = 1; isWord = 1; vaddr = 32'h2;
    l1ExtAbort = 1;
    expectOut("R5 vector over align", 1, 4'b0000, 0);
    @(negedge clk); vaddr = 32'h22;
    expectOut("R6 align", 1, 4'b0001, 0);
    @(negedge clk); vaddr = 32'h24;
    expectOut("R6 mmu off no walk fault", 0, 0, 0);
    @(negedge clk); vaddr = 32'h22; isWord = 0;
    expectOut("R6 byte exempt", 0, 0, 0);
    @(negedge clk); vaddr = 32'h2; isData = 0; isWord = 1;
    expectOut("R5 fetch exempt", 0, 0, 0);
    @(negedge clk); isData = 1; isWord = 0; vaddr = 32'h1F;
    expectOut("R5 top of window", 1, 0, 0);
    @(negedge clk); vaddr = 32'h20;
    expectOut("R5 past window", 0, 0, 0);
    @(negedge clk); mode26 = 0; vaddr = 32'h4;
    expectOut("R5 needs mode26", 0, 0, 0);

    // fault registers: R9 R10
    @(negedge clk); defaults(); descKind = 2'b01; l2Invalid = 1; vaddr = 32'h1234_5000;
    @(negedge clk); l2Invalid = 0;
    check("R9 fsrCode", fsrCode, 4'b0111);
    check("R9 fsrDomain", fsrDomain, 9);
    check("R9 farAddr", farAddr, 32'h1234_5000);
    isData = 0; l1Invalid = 1; vaddr = 32'h5555_0000;
    #1 check("R10 fetch abort flag", abortOut, 1);
    @(negedge clk);
    check("R10 fetch fsrCode", fsrCode, 4'b0111);
    check("R10 fetch farAddr", farAddr, 32'h1234_5000);
    isData = 1; accValid = 0;
    #1 check("R10 idle no abort", abortOut, 0);
    @(negedge clk);
    check("R10 idle farAddr", farAddr, 32'h1234_5000);
    accValid = 1; l1Invalid = 0; descKind = 2'b00; domainAccess = '0; vaddr = 32'h0ABC_0000;
    @(negedge clk);
    check("R9 section domain fsr", fsrCode, 4'b1001);
    check("R9 section far", farAddr, 32'h0ABC_0000);
    accValid = 0;
    @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule